// File: doc/BRIEF.md
# DRAM refresh and initialisation scheduler

This block paces refresh for an asynchronous DRAM behind an access sequencer. After reset it holds off for a power-up pause. It then asks for a short burst of initialisation refresh cycles before it reports the memory usable. From then on it adds one refresh slot per interval, so that every row is visited within the retention period. With the default parameters that is 2048 rows at 15.6 us spacing, which fits inside 32 ms. Slots that the sequencer cannot serve at once are kept in a small backlog and drained back to back. If the backlog would grow past its bound, a sticky error flag is raised.

The block also supervises self-refresh on the low-power variant. Self-refresh is entered only after a full row sweep has completed since initialisation or since the last exit. Entry is preceded by one forced refresh. While self-refresh is active, the row strobe is held for a minimum time of 100 us, so the forbidden 10 to 100 us window is never used. On exit the block waits out the longer self-refresh precharge, issues another forced refresh, and then restarts normal pacing and the row sweep.

The interface to the sequencer is a request level and a one-cycle acknowledge for each completed CAS-before-RAS cycle. All delays are cycle counts whose defaults come from the clock frequency.

Top module: `refresh_sched`

## Requirements
- R1: During reset and after it, ref_req_o, ready_o, sr_active_o and ovf_o are low. ref_req_o rises exactly PAUSE_CYC clock cycles after reset is released.
- R2: After the pause, ref_req_o stays high until INIT_CYCLES acknowledges have been taken. ready_o rises in the cycle after the last of them and not before.
- R3: Once ready, one refresh slot is added every INTERVAL_CYC cycles, the first one INTERVAL_CYC cycles after ready_o rises. ref_req_o is high while at least one slot is outstanding.
- R4: Each acknowledge taken while ref_req_o is high removes one slot. A new slot and an acknowledge in the same cycle leave the backlog unchanged. An acknowledge while ref_req_o is low has no effect.
- R5: The backlog holds up to MAX_PEND slots, and these are served back to back. A new slot arriving at a full backlog without an acknowledge sets ovf_o, which stays high until reset.
- R6: A self-refresh request on sr_cmd_i is acted on only after ROWS normal refresh acknowledges since ready_o rose, or since the last self-refresh exit. Before that it is ignored.
- R7: Self-refresh entry is preceded by exactly one forced refresh. sr_active_o rises in the cycle after that refresh is acknowledged.
- R8: sr_active_o stays high for at least SR_HOLD_CYC cycles, even if sr_cmd_i drops. After that it stays high while sr_cmd_i is high and falls one cycle after sr_cmd_i is seen low.
- R9: After sr_active_o falls, ref_req_o stays low for exactly SR_PRE_CYC cycles. One forced refresh is then requested, after which periodic pacing and the row sweep restart.
- R10: Once high, ready_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_cmd_i | input | 1 | Level request to enter and stay in self-refresh |
| ref_ack_i | input | 1 | One-cycle pulse: sequencer completed a refresh cycle |
| ref_req_o | output | 1 | A refresh cycle is wanted |
| ready_o | output | 1 | Initialisation complete, memory usable |
| sr_active_o | output | 1 | Sequencer must hold the device in self-refresh |
| ovf_o | output | 1 | Sticky: refresh backlog overflowed |

## Verification
The interval tick and the sequencer acknowledge can fall on the same clock edge. When they do, the backlog must neither grow nor shrink. The bench provokes this by counting interval edges itself and placing a manual acknowledge exactly on the tick edge with one slot outstanding, then judging that ref_req_o is still high and that a single further acknowledge clears it. A second collision, between a pending self-refresh command and an incomplete row sweep, is judged by counting acknowledges until entry: the count must be exactly one sweep plus the forced refreshes.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    S_PAUSE, S_INIT, S_RUN, S_PRE, S_SELF, S_PRECH, S_POST
  } sched_st_t;
endpackage

// File: rtl/refresh_pace.sv
module refresh_pace #(
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 4,
  localparam int TW = $clog2(INTERVAL_CYC),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ack_i,
  output logic [PW-1:0] pend_o,
  output logic          ovf_o
);
  localparam logic [TW-1:0] TLAST = TW'(INTERVAL_CYC - 1);
  localparam logic [PW-1:0] PMAX  = PW'(MAX_PEND);

  logic [TW-1:0] tmr;
  logic          tick, take;

  assign tick = run_i && (tmr == TLAST);
  assign take = ack_i && (pend_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr    <= '0;
      pend_o <= '0;
      ovf_o  <= 1'b0;
    end else if (!run_i) begin
      tmr    <= '0;
      pend_o <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick && !take) begin
        if (pend_o == PMAX) ovf_o <= 1'b1;
        else                pend_o <= pend_o + 1'b1;
      end else if (take && !tick) begin
        pend_o <= pend_o - 1'b1;
      end
    end
  end

  a_r4_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o <= PMAX);
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r4_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pend_o == '0));
endmodule

// File: rtl/row_sweep.sv
module row_sweep #(
  parameter int ROWS = 2048,
  localparam int CW = $clog2(ROWS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ack_i,
  output logic done_o
);
  logic [CW-1:0] cnt;

  assign done_o = (cnt == CW'(ROWS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt <= '0;
    else if (clr_i)           cnt <= '0;
    else if (ack_i && !done_o) cnt <= cnt + 1'b1;
  end

  a_r6_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_CYC    = CLK_MHZ * 200,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = (CLK_MHZ * 156) / 10,
  parameter int SR_HOLD_CYC  = CLK_MHZ * 100,
  parameter int SR_PRE_CYC   = (CLK_MHZ * 90 + 999) / 1000,
  parameter int ROWS         = 2048,
  parameter int MAX_PEND     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_cmd_i,
  input  logic ref_ack_i,
  output logic ref_req_o,
  output logic ready_o,
  output logic sr_active_o,
  output logic ovf_o
);
  localparam int DMAX0 = (PAUSE_CYC > SR_HOLD_CYC) ? PAUSE_CYC : SR_HOLD_CYC;
  localparam int DMAX  = (DMAX0 > SR_PRE_CYC) ? DMAX0 : SR_PRE_CYC;
  localparam int DW    = $clog2(DMAX + 1);
  localparam int IW    = $clog2(INIT_CYCLES + 1);
  localparam int PW    = $clog2(MAX_PEND + 1);
  localparam logic [DW-1:0] PAUSE_LAST = DW'(PAUSE_CYC - 1);
  localparam logic [DW-1:0] HOLD_LAST  = DW'(SR_HOLD_CYC - 1);
  localparam logic [DW-1:0] PRE_LAST   = DW'(SR_PRE_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);

  sched_st_t     st;
  logic [DW-1:0] dly;
  logic [IW-1:0] init_cnt;
  logic [PW-1:0] pend;
  logic          run, sweep_done, ack_ok;

  assign run       = (st == S_RUN);
  assign ack_ok    = ref_ack_i && ref_req_o;
  assign ref_req_o = (st == S_INIT) || (st == S_PRE) || (st == S_POST) ||
                     (run && (pend != '0));
  assign ready_o     = (st != S_PAUSE) && (st != S_INIT);
  assign sr_active_o = (st == S_SELF);

  refresh_pace #(.INTERVAL_CYC(INTERVAL_CYC), .MAX_PEND(MAX_PEND)) u_pace (
    .clk_i, .rst_ni, .run_i(run), .ack_i(ref_ack_i && run),
    .pend_o(pend), .ovf_o(ovf_o)
  );

  row_sweep #(.ROWS(ROWS)) u_sweep (
    .clk_i, .rst_ni, .clr_i(!run), .ack_i(ack_ok && run), .done_o(sweep_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_PAUSE;
      dly      <= '0;
      init_cnt <= '0;
    end else begin
      unique case (st)
        S_PAUSE: if (dly == PAUSE_LAST) begin st <= S_INIT; dly <= '0; end
                 else dly <= dly + 1'b1;
        S_INIT:  if (ref_ack_i) begin
                   init_cnt <= init_cnt + 1'b1;
                   if (init_cnt == INIT_LAST) st <= S_RUN;
                 end
        S_RUN:   if (sr_cmd_i && sweep_done) st <= S_PRE;
        S_PRE:   if (ref_ack_i) begin st <= S_SELF; dly <= '0; end
        S_SELF:  if (dly == HOLD_LAST) begin
                   if (!sr_cmd_i) begin st <= S_PRECH; dly <= '0; end
                 end else dly <= dly + 1'b1;
        S_PRECH: if (dly == PRE_LAST) begin st <= S_POST; dly <= '0; end
                 else dly <= dly + 1'b1;
        S_POST:  if (ref_ack_i) st <= S_RUN;
        default: st <= S_PAUSE;
      endcase
    end
  end

  a_r1_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_PAUSE) |-> !ref_req_o && !ready_o);
  a_r2_ready_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(ref_ack_i));
  a_r10_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r6_entry_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_PRE) && ($past(st) == S_RUN) |-> $past(sweep_done && sr_cmd_i));
  a_r7_refresh_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_active_o) |-> $past(ref_ack_i && ref_req_o));
  a_r8_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_active_o && (dly != HOLD_LAST) |=> sr_active_o);
  a_r9_quiet_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_active_o) |-> !ref_req_o);
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int PAUSE = 50, NINIT = 8, INT = 40, HOLD = 100, PRE = 9,
                 ROWS = 16, MAXP = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, sr_cmd_i = 1'b0, ref_ack_i = 1'b0;
  logic ref_req_o, ready_o, sr_active_o, ovf_o;

  int checks = 0, errors = 0, acks = 0, wcnt = 0, lat_max = 4;
  bit auto_en = 1'b0, done = 1'b0;

  always #5 clk_i = ~clk_i;

  refresh_sched #(
    .CLK_MHZ(100), .PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CYC(INT),
    .SR_HOLD_CYC(HOLD), .SR_PRE_CYC(PRE), .ROWS(ROWS), .MAX_PEND(MAXP)
  ) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick_lat();
    return 1 + int'($urandom % lat_max);
  endfunction

  // One clock edge, then sequencer model reacts at the falling edge.
  task automatic step();
    @(negedge clk_i);
    if (ref_ack_i) ref_ack_i = 1'b0;
    else if (auto_en && ref_req_o) begin
      if (wcnt == 0) begin ref_ack_i = 1'b1; acks++; wcnt = pick_lat(); end
      else wcnt--;
    end
  endtask

  task automatic steps(input int n);
    repeat (n) step();
  endtask

  task automatic pulse();
    ref_ack_i = 1'b1;
    acks++;
    step();
  endtask

  task automatic wait_for(input int n, input bit want_active);
    for (int i = 0; i < n; i++) begin
      if (want_active ? sr_active_o : ready_o) break;
      step();
    end
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd20240917));
    // R1: reset state
    #3;
    chk(!ref_req_o && !ready_o && !sr_active_o && !ovf_o, "R1 reset", 0, 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    steps(PAUSE - 1);
    chk(ref_req_o == 1'b0, "R1 pause", ref_req_o, 0);
    chk(ready_o == 1'b0, "R1 pause ready", ready_o, 0);
    step();
    chk(ref_req_o == 1'b1, "R1 pause end", ref_req_o, 1);
    // R2: init burst
    for (int i = 0; i < NINIT - 1; i++) begin
      pulse();
      chk(ready_o == 1'b0 && ref_req_o == 1'b1, "R2 init", ready_o, 0);
    end
    pulse();
    chk(ready_o == 1'b1, "R2 ready", ready_o, 1);
    chk(ref_req_o == 1'b0, "R2 no slot", ref_req_o, 0);
    // R3: first interval
    steps(INT - 1);
    chk(ref_req_o == 1'b0, "R3 early", ref_req_o, 0);
    step();
    chk(ref_req_o == 1'b1, "R3 tick", ref_req_o, 1);
    pulse();
    chk(ref_req_o == 1'b0, "R4 take", ref_req_o, 0);
    pulse();  // stray acknowledge
    chk(ref_req_o == 1'b0, "R4 stray ignored", ref_req_o, 0);
    steps(INT - 2);
    chk(ref_req_o == 1'b1, "R3 second tick", ref_req_o, 1);
    steps(INT - 1);
    pulse();  // lands on the tick edge
    chk(ref_req_o == 1'b1, "R4 tick with ack", ref_req_o, 1);
    pulse();
    chk(ref_req_o == 1'b0, "R4 single slot left", ref_req_o, 0);
    // R5: backlog fill and overflow
    steps(INT - 1);
    steps(2 * INT);
    chk(ovf_o == 1'b0 && ref_req_o == 1'b1, "R5 full no ovf", ovf_o, 0);
    steps(INT);
    chk(ovf_o == 1'b1, "R5 overflow", ovf_o, 1);
    pulse(); pulse();
    chk(ref_req_o == 1'b1, "R5 drain", ref_req_o, 1);
    pulse();
    chk(ref_req_o == 1'b0, "R5 drained", ref_req_o, 0);
    chk(ovf_o == 1'b1, "R5 sticky", ovf_o, 1);
    // R1: reset in operation
    rst_ni = 1'b0;
    #1;
    chk(!ovf_o && !ready_o && !ref_req_o, "R1 rerun reset", ovf_o, 0);
    step(); step();
    rst_ni = 1'b1;
    auto_en = 1'b1;
    sr_cmd_i = 1'b1;
    wait_for(PAUSE + 200, 1'b0);
    chk(ready_o == 1'b1, "R2 auto init", ready_o, 1);
    acks = 0;
    // R6/R7: entry waits for the full sweep plus one forced refresh
    wait_for(ROWS * INT + 400, 1'b1);
    chk(sr_active_o == 1'b1, "R6 entered", sr_active_o, 1);
    chk(acks == ROWS + 1, "R7 acks before entry", acks, ROWS + 1);
    // R8: minimum hold with command already dropped
    sr_cmd_i = 1'b0;
    cnt = 1;
    for (int i = 0; i < HOLD + 10; i++) begin
      step();
      if (!sr_active_o) break;
      cnt++;
    end
    chk(cnt == HOLD, "R8 min hold", cnt, HOLD);
    acks = 0;
    // R9: exit precharge
    cnt = 1;
    for (int i = 0; i < PRE + 10; i++) begin
      step();
      if (ref_req_o) break;
      cnt++;
    end
    chk(cnt == PRE, "R9 precharge", cnt, PRE);
    sr_cmd_i = 1'b1;
    wait_for(ROWS * INT + 400, 1'b1);
    chk(acks == ROWS + 2, "R9 post refresh and R6 sweep", acks, ROWS + 2);
    // R8: extended hold under command
    cnt = 1;
    for (int i = 0; i < HOLD + 24; i++) begin
      step();
      cnt += sr_active_o ? 1 : 0;
    end
    chk(cnt == HOLD + 25, "R8 held by command", cnt, HOLD + 25);
    sr_cmd_i = 1'b0;
    step();
    chk(sr_active_o == 1'b0, "R8 release", sr_active_o, 0);
    chk(ready_o == 1'b1, "R10 ready kept", ready_o, 1);
    // R3/R5: random latency pacing
    lat_max = INT / 4;
    steps(3 * INT);
    acks = 0;
    steps(50 * INT);
    chk(acks >= 49 && acks <= 51, "R3 rate", acks, 50);
    chk(ovf_o == 1'b0, "R5 no overflow", ovf_o, 0);
    chk(ready_o == 1'b1 && sr_active_o == 1'b0, "R10 final", ready_o, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule